// File: doc/BRIEF.md
# Software Task Selector

This block chooses, on every clock cycle, which ready task a single software processor runs next. Each of a fixed number of task slots presents a ready flag, an earliest-start time, an urgency value and an execution time. Among the ready slots the block applies a cascade of comparisons. It keeps the tasks with the smallest earliest-start time. If more than one remains, it keeps those with the largest urgency. If a tie still remains, it keeps those with the longest execution time. Any tie left after that goes to the lowest slot index.

The block registers the chosen task as a one-hot vector, together with the time at which that task may start. It also tracks the time until which the processor is busy. The start time is the later of the task's earliest-start time and the current busy-until time. The task's execution time is then added to the start time to give the new busy-until time. A system with two software processors uses two identical copies, one per processor. Neither copy has precedence over the other.

Top module: `sw_task_picker`

## Requirements
- R1: Among the ready slots, a slot whose earliest-start time is strictly smaller than that of every other ready slot is the one selected.
- R2: When several ready slots share the smallest earliest-start time, the one among them with the strictly largest urgency is selected.
- R3: When several ready slots share both the smallest earliest-start time and the largest urgency among those, the one with the strictly largest execution time is selected.
- R4: A tie that survives all three comparisons is won by the slot with the lowest index.
- R5: `sched_o` is one-hot whenever `valid_o` is 1, and it only ever marks a slot whose ready flag was 1 in the previous cycle. A slot that is not ready is never chosen, whatever its values. The result appears on the clock edge after the inputs are presented.
- R6: `start_o` equals the larger of the chosen slot's earliest-start time and the value `busy_o` held before the selecting edge.
- R7: After a selection, `busy_o` equals the new `start_o` plus the chosen slot's execution time, modulo 2^TW.
- R8: A cycle with no ready slot leaves `sched_o` at zero and `valid_o` at 0. `busy_o` and `start_o` keep their values.
- R9: With `rst_n` low at a clock edge, `sched_o`, `valid_o`, `start_o` and `busy_o` all become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ready_i | input | N_TASKS | Per-slot ready flag, bit i for slot i |
| asap_i | input | N_TASKS*TW | Earliest-start times, slot i in bits [i*TW +: TW] |
| urg_i | input | N_TASKS*UW | Urgency values, slot i in bits [i*UW +: UW] |
| texe_i | input | N_TASKS*TW | Execution times, slot i in bits [i*TW +: TW] |
| sched_o | output | N_TASKS | One-hot chosen slot (registered) |
| valid_o | output | 1 | A slot was chosen on the last edge |
| start_o | output | TW | Start time of the chosen slot |
| busy_o | output | TW | Processor busy-until time |

## Verification
The hardest case to reach is a tie that passes all three comparisons, or one that ends at the execution-time comparison. Several ready slots must carry exactly equal values in two or three fields at once, and uniformly drawn values almost never do that. The bench uses directed cycles that build each tie on purpose. It then runs a long stretch of random cycles in which every field is drawn from only a few values, so ties at each level happen often. A behavioural reference model predicts the choice and the time bookkeeping for every cycle, including cycles with no ready slot and a reset in the middle of a run.

// File: rtl/swsel_pkg.sv
// Shared definitions for the software task selector.
// Assumes nothing beyond a standard SystemVerilog elaborator.
package swsel_pkg;

    // Direction in which a criterion filter looks for its extreme value.
    typedef enum logic {
        CRIT_MIN = 1'b0,
        CRIT_MAX = 1'b1
    } crit_dir_e;

endpackage

// File: rtl/swsel_crit_filter.sv
// One stage of the tie-break cascade. From the candidate mask it keeps only
// the slots whose value equals the extreme (minimum or maximum, set by DIR)
// over all candidates. Purely combinational.
// Assumes: when no candidate is set, the output mask is all zero.
module swsel_crit_filter
    import swsel_pkg::*;
#(
    parameter int        N   = 8,
    parameter int        W   = 16,
    parameter crit_dir_e DIR = CRIT_MIN
) (
    input  logic [N-1:0]   cand_i,
    input  logic [N*W-1:0] val_i,
    output logic [N-1:0]   keep_o
);

    logic [W-1:0] best;

    // Find the extreme value over the candidate slots; the comparator is picked by DIR.
    generate
        if (DIR == CRIT_MIN) begin : g_min
            always_comb begin
                best = '1;
                for (int i = 0; i < N; i++) begin
                    if (cand_i[i] && (val_i[i*W +: W] < best)) best = val_i[i*W +: W];
                end
            end
        end else begin : g_max
            always_comb begin
                best = '0;
                for (int i = 0; i < N; i++) begin
                    if (cand_i[i] && (val_i[i*W +: W] > best)) best = val_i[i*W +: W];
                end
            end
        end
    endgenerate

    // Keep every candidate that matches the extreme value.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            keep_o[i] = cand_i[i] && (val_i[i*W +: W] == best);
        end
    end

endmodule

// File: rtl/swsel_first_pick.sv
// Reduces a request mask to a one-hot vector marking the lowest set index.
// Purely combinational. Assumes: an all-zero request gives an all-zero pick.
module swsel_first_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] pick_o
);

    logic found;

    // Scan from slot 0 upward and mark the first request seen.
    always_comb begin
        pick_o = '0;
        found  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !found) begin
                pick_o[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sw_task_picker.sv
// Per-processor software task selector. Each cycle it picks one ready slot:
// smallest earliest-start time, then largest urgency, then longest execution
// time, then lowest index. It registers the one-hot choice and its start time,
// and advances the processor's busy-until time.
// Assumes: time values do not wrap within a run (TW is wide enough), and the
// inputs are stable around the rising clock edge. Reset is synchronous, active low.
module sw_task_picker
    import swsel_pkg::*;
#(
    parameter int N_TASKS = 8,
    parameter int TW      = 16,
    parameter int UW      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_TASKS-1:0]    ready_i,
    input  logic [N_TASKS*TW-1:0] asap_i,
    input  logic [N_TASKS*UW-1:0] urg_i,
    input  logic [N_TASKS*TW-1:0] texe_i,
    output logic [N_TASKS-1:0]    sched_o,
    output logic                  valid_o,
    output logic [TW-1:0]         start_o,
    output logic [TW-1:0]         busy_o
);

    localparam int NT = N_TASKS;

    logic [NT-1:0] asap_keep;
    logic [NT-1:0] urg_keep;
    logic [NT-1:0] texe_keep;
    logic [NT-1:0] sel_oh;
    logic [TW-1:0] sel_asap;
    logic [TW-1:0] sel_texe;
    logic [TW-1:0] start_nxt;
    logic          any_ready;

    assign any_ready = |ready_i;

    swsel_crit_filter #(.N(NT), .W(TW), .DIR(CRIT_MIN)) u_asap (
        .cand_i (ready_i),
        .val_i  (asap_i),
        .keep_o (asap_keep)
    );

    swsel_crit_filter #(.N(NT), .W(UW), .DIR(CRIT_MAX)) u_urg (
        .cand_i (asap_keep),
        .val_i  (urg_i),
        .keep_o (urg_keep)
    );

    swsel_crit_filter #(.N(NT), .W(TW), .DIR(CRIT_MAX)) u_texe (
        .cand_i (urg_keep),
        .val_i  (texe_i),
        .keep_o (texe_keep)
    );

    swsel_first_pick #(.N(NT)) u_pick (
        .req_i  (texe_keep),
        .pick_o (sel_oh)
    );

    // One-hot select of the chosen slot's earliest-start and execution times.
    always_comb begin
        sel_asap = '0;
        sel_texe = '0;
        for (int i = 0; i < NT; i++) begin
            if (sel_oh[i]) begin
                sel_asap = sel_asap | asap_i[i*TW +: TW];
                sel_texe = sel_texe | texe_i[i*TW +: TW];
            end
        end
    end

    // Start no earlier than the task allows and no earlier than the processor frees up.
    assign start_nxt = (sel_asap > busy_o) ? sel_asap : busy_o;

    // Register the choice and advance the busy-until time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sched_o <= '0;
            valid_o <= 1'b0;
            start_o <= '0;
            busy_o  <= '0;
        end else if (any_ready) begin
            sched_o <= sel_oh;
            valid_o <= 1'b1;
            start_o <= start_nxt;
            busy_o  <= start_nxt + sel_texe;
        end else begin
            sched_o <= '0;
            valid_o <= 1'b0;
        end
    end

    // ---------------- assertions ----------------
    p_onehot_sched_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $onehot(sched_o))
        else $error("sched_o not one-hot while valid");

    p_valid_matches_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (sched_o == '0))
        else $error("sched_o set without valid");

    p_chosen_was_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        any_ready |=> ((sched_o & ~$past(ready_i)) == '0) && valid_o)
        else $error("selected slot was not ready");

    p_filter_subset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((asap_keep & ~ready_i) == '0) && ((urg_keep & ~asap_keep) == '0)
            && (any_ready == (texe_keep != '0)))
        else $error("criterion cascade lost or invented a candidate");

    p_start_not_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_ready |=> (start_o >= $past(busy_o)))
        else $error("start earlier than previous busy-until time");

    p_busy_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (busy_o >= start_o))
        else $error("busy-until time before start time");

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_ready |=> (!valid_o && $stable(busy_o) && $stable(start_o)))
        else $error("state changed on a cycle with no ready slot");

    p_reset_clears_r9: assert property (@(posedge clk)
        !rst_n |=> (sched_o == '0 && !valid_o && busy_o == '0 && start_o == '0))
        else $error("reset did not clear outputs");

endmodule

// File: tb/sim_sw_task_picker.sv
// Bench for sw_task_picker: behavioural reference model compared every clock.
module sim_sw_task_picker;

    localparam int N  = 8;
    localparam int TW = 16;
    localparam int UW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      ready_i = '0;
    logic [N*TW-1:0]   asap_i = '0;
    logic [N*UW-1:0]   urg_i = '0;
    logic [N*TW-1:0]   texe_i = '0;
    logic [N-1:0]      sched_o;
    logic              valid_o;
    logic [TW-1:0]     start_o;
    logic [TW-1:0]     busy_o;

    int checks = 0;
    int errors = 0;

    int a [N];
    int u [N];
    int t [N];
    logic [N-1:0] rdy;

    // reference model state
    logic [TW-1:0] m_busy = '0;
    logic [TW-1:0] m_start = '0;
    logic [N-1:0]  m_sched = '0;
    logic          m_valid = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sw_task_picker #(.N_TASKS(N), .TW(TW), .UW(UW)) u0 (
        .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .asap_i(asap_i),
        .urg_i(urg_i), .texe_i(texe_i), .sched_o(sched_o), .valid_o(valid_o),
        .start_o(start_o), .busy_o(busy_o)
    );

    // watchdog: an expired run is a failed check
    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic drive();
        for (int i = 0; i < N; i++) begin
            asap_i[i*TW +: TW] = TW'(a[i]);
            urg_i[i*UW +: UW]  = UW'(u[i]);
            texe_i[i*TW +: TW] = TW'(t[i]);
        end
        ready_i = rdy;
    endtask

    // Reference choice: strict better-than ordering keeps the lowest index on full ties.
    function automatic int ref_pick();
        int best = -1;
        for (int i = 0; i < N; i++) begin
            if (rdy[i]) begin
                if (best < 0) best = i;
                else if (a[i] < a[best]) best = i;
                else if (a[i] == a[best] && u[i] > u[best]) best = i;
                else if (a[i] == a[best] && u[i] == u[best] && t[i] > t[best]) best = i;
            end
        end
        return best;
    endfunction

    // Drive current arrays, advance one clock, compare against the model.
    task automatic step(input string tag);
        int k;
        drive();
        k = ref_pick();
        if (k >= 0) begin
            m_start = (TW'(a[k]) > m_busy) ? TW'(a[k]) : m_busy;
            m_busy  = m_start + TW'(t[k]);
            m_sched = N'(1) << k;
            m_valid = 1'b1;
        end else begin
            m_sched = '0;
            m_valid = 1'b0;
        end
        @(negedge clk);
        check(tag, "valid_o", valid_o, m_valid);
        check(tag, "sched_o", sched_o, m_sched);
        check(tag, "start_o", start_o, m_start);
        check(tag, "busy_o",  busy_o,  m_busy);
    endtask

    task automatic reset_check();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        m_busy = '0; m_start = '0; m_sched = '0; m_valid = 1'b0;
        check("R9", "sched_o", sched_o, 0);
        check("R9", "valid_o", valid_o, 0);
        check("R9", "start_o", start_o, 0);
        check("R9", "busy_o",  busy_o,  0);
        rst_n = 1'b1;
    endtask

    task automatic fill(input int av, input int uv, input int tv);
        for (int i = 0; i < N; i++) begin
            a[i] = av; u[i] = uv; t[i] = tv;
        end
    endtask

    initial begin
        fill(0, 0, 0);
        rdy = '0;
        drive();
        repeat (2) @(negedge clk);
        reset_check();

        // R1: unique minimum earliest-start wins (slot 5)
        fill(20, 9, 9); a[5] = 3; a[2] = 4; rdy = '1;
        step("R1");
        // R2: slots 1 and 3 tie on earliest start; 3 has higher urgency
        fill(30, 0, 1); a[1] = 10; a[3] = 10; u[1] = 2; u[3] = 7; t[1] = 9;
        rdy = '1; step("R2");
        // R3: slots 2 and 6 tie on start and urgency; 6 runs longer
        fill(50, 1, 1); a[2] = 40; a[6] = 40; u[2] = 5; u[6] = 5; t[2] = 3; t[6] = 8;
        rdy = '1; step("R3");
        // R4: slots 4 and 7 tie on all three; lowest index wins
        fill(90, 0, 0); a[4] = 60; a[7] = 60; u[4] = 3; u[7] = 3; t[4] = 5; t[7] = 5;
        rdy = '1; step("R4");
        // R6: earliest start below busy-until, start follows busy-until
        fill(0, 0, 2); rdy = 8'b0000_0001; step("R6");
        // R6: earliest start above busy-until, start follows earliest start
        fill(500, 0, 4); rdy = 8'b0000_0010; step("R6");
        // R8: no ready slot holds busy-until and start
        fill(1, 9, 9); rdy = '0; step("R8");
        step("R8");
        // R5: a better slot that is not ready is ignored
        fill(700, 0, 1); a[0] = 0; u[0] = 99; rdy = 8'b1000_0000; step("R5");
        // R7: execution time adds onto start
        fill(800, 0, 0); t[3] = 25; rdy = 8'b0000_1000; step("R7");

        // random phase with narrow value ranges to force ties at every level
        for (int c = 0; c < 400; c++) begin
            for (int i = 0; i < N; i++) begin
                a[i] = int'(m_busy) + int'($urandom_range(0, 3));
                u[i] = int'($urandom_range(0, 2));
                t[i] = int'($urandom_range(0, 3));
            end
            rdy = N'($urandom) & N'($urandom);
            if (c % 17 == 0) rdy = '0;
            step("R1/R2/R3/R4/R7");
        end

        // mid-run reset
        reset_check();
        fill(5, 1, 2); rdy = 8'b0110_0000; step("R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule